// File: doc/BRIEF.md
# One-Time-Programmable Fuse Sequencer

This block sits between a register bus and a one-time-programmable fuse macro. It runs two kinds of operation on a single addressed fuse word. A sense reads the word back into a result register. A program burns a 32-bit value into the word. Software first loads a timing register, which sets the strobe lengths and the relax spacing. It then selects the word and, for a program, supplies an unlock key through the control register. Writing the start bit or the data register launches the operation. Software polls busy until it drops and then checks the sticky error flag.

For every operation the controller latches the address, the data and the timing. It then holds the macro strobe low for a relax period, raises it for the active part of the operation, and holds it low for a second relax period. The strobe length that software programs already counts both relax periods. The block refuses any program that lacks the key, and any start request that arrives while an operation is still running. In both cases it raises the error flag instead. Software clears the flag by writing a one through a separate clear alias.

Top module: `fuse_seq_ctrl`

## Requirements
- R1: After reset, the control register (offset 0), the timing register (offset 2) and the read-result register (offset 5) all read as zero, and the fuse strobe is low.
- R2: Control bits [6:0] hold the word address {bank[3:0], word[2:0]}. While an operation is busy, fz_addr carries the address that was latched when the operation started.
- R3: Writing a 1 in bit 0 of the read-start register (offset 3) senses the addressed word. The value sensed during the last active strobe cycle is readable at offset 5 once busy has fallen.
- R4: Writing the data register (offset 4) while control bits [31:16] equal 0x3E77 programs the addressed word. During the strobe, fz_prog is high and fz_wdata carries the written value.
- R5: A data-register write with any other key value sets the error flag. It raises neither busy nor the strobe, and it leaves the fuse word unchanged.
- R6: After any data-register write, the unlock field (control bits [31:16]) reads zero.
- R7: Busy (control bit 8) stays high for E+1 cycles. E is max(S, 2*(relax+1)), and S is the read strobe field for a sense or the program strobe field for a program.
- R8: The strobe stays low for the first relax+1 busy cycles and for the last relax+1 busy cycles. It is high in every busy cycle between those two periods, so it is high for E-2*(relax+1)+1 cycles.
- R9: The error flag (control bit 9) is sticky. Writing a 1 to bit 9 at the clear alias (offset 1) clears it; writing a 0 there leaves it set.
- R10: A write to the data register, or a write of 1 to the read-start bit, while busy is high is ignored and sets the error flag.
- R11: A read-start write with bit 0 equal to 0 starts nothing and leaves the read-result register unchanged.
- R12: The timing register holds the read strobe count in bits [21:16], the relax count in [15:12] and the program strobe count in [11:0], and reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| fz_strobe | output | 1 | Fuse macro strobe |
| fz_prog | output | 1 | High while a program operation is running |
| fz_addr | output | 7 | Fuse word address {bank, word} |
| fz_wdata | output | 32 | Value to burn during a program |
| fz_rdata | input | 32 | Sensed word returned by the macro |

## Verification
A table of mixed sense and program operations runs against a behavioural fuse array. The array can only OR bits into a word.

Sensing a preset word shows that the result comes from the macro rather than from a reset value. Programming the same word twice, the second time with an overlapping value, shows that an existing 1 stays set. Programming all ones in the highest bank and word exercises the edges of the address field. A program with a wrong key, followed by a sense of the same word, separates a refused program from an accepted one.

Directed runs then measure busy length, strobe length and the position of the first strobe cycle. These runs cover long strobe counts, a count shorter than the two relax periods (which is clamped), and a zero relax count. Separate directed checks cover starts while busy, a start write with bit 0 clear, and the clear alias.

// File: rtl/fuse_ctl_pkg.sv
package fuse_ctl_pkg;

    localparam int REG_W   = 32;
    localparam int RD_W    = 6;
    localparam int RLX_W   = 4;
    localparam int PG_W    = 12;
    localparam int CNT_W   = PG_W;
    localparam int KEY_W   = 16;
    localparam int KEY_LSB = 16;
    localparam int BUSY_BIT = 8;
    localparam int ERR_BIT  = 9;
    localparam int TIM_W    = RD_W + RLX_W + PG_W;

    localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'h3E77;

    typedef enum logic [2:0] {
        REG_CTRL     = 3'd0,
        REG_CTRL_CLR = 3'd1,
        REG_TIMING   = 3'd2,
        REG_RSTART   = 3'd3,
        REG_DATA     = 3'd4,
        REG_RRESULT  = 3'd5
    } reg_sel_e;

    // Field order matches the timing register bits [21:0].
    typedef struct packed {
        logic [RD_W-1:0]  rd;
        logic [RLX_W-1:0] rlx;
        logic [PG_W-1:0]  pg;
    } timing_t;

    // The strobe count already includes two relax periods; a count that is
    // too short is raised so that the active part lasts one cycle.
    function automatic logic [CNT_W-1:0] eff_len(input logic [CNT_W-1:0] len,
                                                  input logic [RLX_W-1:0] rlx);
        logic [CNT_W-1:0] floor_v;
        floor_v = (CNT_W'(rlx) + CNT_W'(1)) << 1;
        return (len < floor_v) ? floor_v : len;
    endfunction

endpackage

// File: rtl/fuse_regfile.sv
module fuse_regfile
    import fuse_ctl_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [2:0]        addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              busy,
    input  logic              cap_en,
    input  logic [REG_W-1:0]  sense_val,
    output logic              start_sense,
    output logic              start_prog,
    output logic              key_ok,
    output logic [ADDR_W-1:0] word_addr,
    output timing_t           timing
);

    logic [KEY_W-1:0]  unlock_q;
    logic [ADDR_W-1:0] addr_q;
    timing_t           timing_q;
    logic              err_q;
    logic [REG_W-1:0]  result_q;

    logic wr_ctrl, wr_clr, wr_tim, wr_rstart, wr_data;
    logic err_set, err_clr;

    always_comb begin
        wr_ctrl   = we && (addr == REG_CTRL);
        wr_clr    = we && (addr == REG_CTRL_CLR);
        wr_tim    = we && (addr == REG_TIMING);
        wr_rstart = we && (addr == REG_RSTART) && wdata[0];
        wr_data   = we && (addr == REG_DATA);
        key_ok    = (unlock_q == UNLOCK_KEY);

        start_sense = wr_rstart && !busy;
        start_prog  = wr_data && !busy && key_ok;

        err_set = (wr_data && (busy || !key_ok)) || (wr_rstart && busy);
        err_clr = wr_clr && wdata[ERR_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            unlock_q <= '0;
            addr_q   <= '0;
            timing_q <= '0;
            err_q    <= 1'b0;
            result_q <= '0;
        end else begin
            if (wr_ctrl) begin
                unlock_q <= wdata[KEY_LSB +: KEY_W];
                addr_q   <= wdata[ADDR_W-1:0];
            end
            if (wr_data)
                unlock_q <= '0;
            if (wr_tim)
                timing_q <= wdata[TIM_W-1:0];
            if (err_set)
                err_q <= 1'b1;
            else if (err_clr)
                err_q <= 1'b0;
            if (cap_en)
                result_q <= sense_val;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            REG_CTRL, REG_CTRL_CLR: begin
                rdata[KEY_LSB +: KEY_W] = unlock_q;
                rdata[ERR_BIT]          = err_q;
                rdata[BUSY_BIT]         = busy;
                rdata[ADDR_W-1:0]       = addr_q;
            end
            REG_TIMING:  rdata[TIM_W-1:0] = timing_q;
            REG_RRESULT: rdata = result_q;
            default:     rdata = '0;
        endcase
    end

    assign word_addr = addr_q;
    assign timing    = timing_q;

    // R10
    err_on_busy_chk: assert property (@(posedge clk) disable iff (rst)
        ((wr_data || wr_rstart) && busy) |=> err_q);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_q && !err_clr) |=> err_q);

    // R6
    unlock_clear_chk: assert property (@(posedge clk) disable iff (rst)
        wr_data |=> (unlock_q == '0));

endmodule

// File: rtl/fuse_strobe_timer.sv
module fuse_strobe_timer
    import fuse_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  len,
    input  logic [RLX_W-1:0]  relax,
    output logic              busy,
    output logic              strobe,
    output logic              last_active
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] r1_q;
    logic             busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            len_q  <= '0;
            r1_q   <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= eff_len(len, relax);
            len_q  <= eff_len(len, relax);
            r1_q   <= CNT_W'(relax) + CNT_W'(1);
        end else if (busy_q) begin
            if (cnt_q == '0)
                busy_q <= 1'b0;
            else
                cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Down-count from len to 0: the top r1 and bottom r1 values are relax.
    always_comb begin
        strobe      = busy_q && (cnt_q >= r1_q) && (cnt_q <= (len_q - r1_q));
        last_active = busy_q && (cnt_q == r1_q);
    end

    assign busy = busy_q;

    // R8
    lead_relax_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> !strobe);

    // R8
    tail_relax_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> $past(!strobe));

endmodule

// File: rtl/fuse_seq_ctrl.sv
module fuse_seq_ctrl
    import fuse_ctl_pkg::*;
#(
    parameter  int BANK_W = 4,
    parameter  int WORD_W = 3,
    localparam int ADDR_W = BANK_W + WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              fz_strobe,
    output logic              fz_prog,
    output logic [ADDR_W-1:0] fz_addr,
    output logic [REG_W-1:0]  fz_wdata,
    input  logic [REG_W-1:0]  fz_rdata
);

    logic              start_sense, start_prog, key_ok;
    logic              busy, last_active, cap_en;
    logic [ADDR_W-1:0] word_addr;
    timing_t           timing;
    logic [CNT_W-1:0]  op_len;

    logic              op_prog_q;
    logic [ADDR_W-1:0] op_addr_q;
    logic [REG_W-1:0]  op_data_q;

    fuse_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .we          (reg_we),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .rdata       (reg_rdata),
        .busy        (busy),
        .cap_en      (cap_en),
        .sense_val   (fz_rdata),
        .start_sense (start_sense),
        .start_prog  (start_prog),
        .key_ok      (key_ok),
        .word_addr   (word_addr),
        .timing      (timing)
    );

    assign op_len = start_prog ? timing.pg : CNT_W'(timing.rd);

    fuse_strobe_timer u_timer (
        .clk         (clk),
        .rst         (rst),
        .start       (start_sense || start_prog),
        .len         (op_len),
        .relax       (timing.rlx),
        .busy        (busy),
        .strobe      (fz_strobe),
        .last_active (last_active)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_prog_q <= 1'b0;
            op_addr_q <= '0;
            op_data_q <= '0;
        end else if (start_sense || start_prog) begin
            op_prog_q <= start_prog;
            op_addr_q <= word_addr;
            op_data_q <= start_prog ? reg_wdata : '0;
        end
    end

    assign cap_en   = last_active && !op_prog_q;
    assign fz_prog  = busy && op_prog_q;
    assign fz_addr  = op_addr_q;
    assign fz_wdata = op_data_q;

    // R4
    prog_needs_key_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && op_prog_q) |-> $past(key_ok));

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || $stable(fz_addr)));

endmodule

// File: tb/fuse_seq_ctrl_bench.sv
module fuse_seq_ctrl_bench;

    typedef struct packed {
        logic        prog;
        logic [3:0]  bank;
        logic [2:0]  word;
        logic [15:0] key;
        logic [31:0] data;   // program value, or expected sensed value
        logic        exp_err;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd0,  3'd5, 16'h0000, 32'h0000_00F0, 1'b0},
        '{1'b1, 4'd2,  3'd3, 16'h3E77, 32'h1234_0001, 1'b0},
        '{1'b0, 4'd2,  3'd3, 16'h0000, 32'h1234_0001, 1'b0},
        '{1'b1, 4'd2,  3'd3, 16'h3E77, 32'h0000_8000, 1'b0},
        '{1'b0, 4'd2,  3'd3, 16'h0000, 32'h1234_8001, 1'b0},
        '{1'b1, 4'd2,  3'd3, 16'h3E77, 32'h0000_0000, 1'b0},
        '{1'b0, 4'd2,  3'd3, 16'h0000, 32'h1234_8001, 1'b0},
        '{1'b1, 4'd15, 3'd7, 16'h3E77, 32'hFFFF_FFFF, 1'b0},
        '{1'b0, 4'd15, 3'd7, 16'h0000, 32'hFFFF_FFFF, 1'b0},
        '{1'b1, 4'd1,  3'd0, 16'h1234, 32'h0000_AAAA, 1'b1},
        '{1'b0, 4'd1,  3'd0, 16'h0000, 32'h0000_0000, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fz_strobe, fz_prog;
    logic [6:0]  fz_addr;
    logic [31:0] fz_wdata, fz_rdata;

    logic [31:0] fuse_mem [128];

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fuse_seq_ctrl u_fuse_seq_ctrl (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fz_strobe(fz_strobe),
        .fz_prog(fz_prog), .fz_addr(fz_addr), .fz_wdata(fz_wdata),
        .fz_rdata(fz_rdata)
    );

    // Behavioural fuse array: bits can only be set.
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 128; i++) fuse_mem[i] <= '0;
            fuse_mem[5] <= 32'h0000_00F0;
        end else if (fz_strobe && fz_prog) begin
            fuse_mem[fz_addr] <= fuse_mem[fz_addr] | fz_wdata;
        end
    end
    assign fz_rdata = fuse_mem[fz_addr];

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            summary();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int off, input logic [31:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'(off); reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 3'd0;
        #1;
    endtask

    task automatic rd(input int off, output logic [31:0] val);
        reg_addr = 3'(off);
        #1;
        val = reg_rdata;
        reg_addr = 3'd0;
        #1;
    endtask

    task automatic wait_idle();
        logic [31:0] c;
        for (int k = 0; k < 5000; k++) begin
            rd(0, c);
            if (!c[8]) return;
            @(negedge clk);
        end
    endtask

    // Starts an operation and measures busy cycles, strobe cycles and the
    // busy-cycle index of the first strobe.
    task automatic measure(input int off, input logic [31:0] val,
                           output int nb, output int ns, output int first);
        logic [31:0] c;
        nb = 0; ns = 0; first = -1;
        wr(off, val);
        for (int k = 0; k < 5000; k++) begin
            rd(0, c);
            if (!c[8]) break;
            if (fz_strobe) begin
                if (first < 0) first = nb;
                ns++;
            end
            nb++;
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        logic [31:0] v, c;
        int nb, ns, first;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;

        // R1: reset state
        rd(0, v); check("R1 ctrl", v, 32'h0);
        rd(2, v); check("R1 timing", v, 32'h0);
        rd(5, v); check("R1 result", v, 32'h0);
        check("R1 strobe", {31'b0, fz_strobe}, 32'h0);

        // R12: timing layout readback
        wr(2, 32'h0008_100C);
        rd(2, v); check("R12 timing", v, 32'h0008_100C);

        // Table walk: R2 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            wait_idle();
            wr(1, 32'h0000_0200);
            wr(0, {VECS[i].key, 9'b0, VECS[i].bank, VECS[i].word});
            if (VECS[i].prog) begin
                wr(4, VECS[i].data);
                rd(0, c);
                if (VECS[i].exp_err)
                    check("R5 no busy", {31'b0, c[8]}, 32'h0);
                else
                    check("R4 busy", {31'b0, c[8]}, 32'h1);
                check("R6 unlock", {16'b0, c[31:16]}, 32'h0);
            end else begin
                wr(3, 32'h1);
                check("R2 fz_addr", {25'b0, fz_addr}, {25'b0, VECS[i].bank, VECS[i].word});
            end
            wait_idle();
            rd(0, c);
            check(VECS[i].prog ? "R4 R5 err" : "R3 err", {31'b0, c[9]}, {31'b0, VECS[i].exp_err});
            if (!VECS[i].prog) begin
                rd(5, v);
                check("R3 R4 sense", v, VECS[i].data);
            end
        end

        // R7 R8: long program strobe, pg=20 relax=2
        wr(1, 32'h200);
        wr(2, 32'h0000_2014);
        wr(0, {16'h3E77, 9'b0, 4'd3, 3'd1});
        measure(4, 32'h1, nb, ns, first);
        check("R7 busy long", nb, 21);
        check("R8 strobe long", ns, 15);
        check("R8 lead relax", first, 3);

        // R7 R8: count below two relax periods is clamped
        wr(2, 32'h0000_2003);
        wr(0, {16'h3E77, 9'b0, 4'd3, 3'd2});
        measure(4, 32'h2, nb, ns, first);
        check("R7 busy short", nb, 7);
        check("R8 strobe short", ns, 1);
        check("R8 lead short", first, 3);

        // R7 R8: sense with zero relax, rd=10
        wr(2, 32'h000A_0000);
        wr(0, {16'h0, 9'b0, 4'd3, 3'd1});
        measure(3, 32'h1, nb, ns, first);
        check("R7 busy sense", nb, 11);
        check("R8 strobe sense", ns, 9);
        check("R8 lead sense", first, 1);
        rd(5, v); check("R3 sense b3w1", v, 32'h1);

        // R10: starts while busy are ignored and flag error
        wr(1, 32'h200);
        wr(2, 32'h0028_0000);
        wr(0, {16'h3E77, 9'b0, 4'd4, 3'd4});
        wr(3, 32'h1);
        wr(4, 32'hFFFF_0000);
        rd(0, c); check("R10 err data", {31'b0, c[9]}, 32'h1);
        wr(1, 32'h200);
        wr(3, 32'h1);
        rd(0, c); check("R10 err rstart", {31'b0, c[9]}, 32'h1);
        wait_idle();
        rd(5, v); check("R10 word untouched", v, 32'h0);

        // R9: writing 0 at the clear alias keeps error; 1 clears it
        wr(1, 32'h0);
        rd(0, c); check("R9 sticky", {31'b0, c[9]}, 32'h1);
        wr(1, 32'h200);
        rd(0, c); check("R9 clear", {31'b0, c[9]}, 32'h0);

        // R11: start bit clear does nothing
        wr(0, {16'h0, 9'b0, 4'd0, 3'd5});
        wr(3, 32'h0000_0002);
        rd(0, c); check("R11 no busy", {31'b0, c[8]}, 32'h0);
        rd(5, v); check("R11 result kept", v, 32'h0);

        done = 1;
        summary();
    end

endmodule